// File: doc/BRIEF.md
# Three-Bus Register Datapath with Fetch Sequencer

This block is a small processor core built on three internal buses. Two read ports of a register file place operands on bus A and bus B in the same cycle. The ALU result returns on bus C to the register file's single write port. A separate incrementer advances the program counter, so the ALU is never needed to step to the next instruction. The ALU also has two pass-through modes that copy one input to bus C unchanged. These modes move the program counter, the memory data register and plain register copies across the datapath.

Each instruction takes four control steps: FETCH, WAIT, LOADIR and EXEC. In FETCH the program counter goes out on bus B and passes through the ALU to the memory address register, and the incrementer bumps the program counter. In WAIT the core strobes a read and stays there until memory signals completion, and the returned word is captured in the memory data register. In LOADIR the memory data register goes out on bus B and passes into the instruction register. In EXEC the decoded instruction runs, and the sequencer then returns to FETCH. The transitions are: FETCH to WAIT always, WAIT to WAIT while completion is low, WAIT to LOADIR on completion, LOADIR to EXEC always, and EXEC to FETCH always.

Top module: `tribus_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the read strobe is low. The first fetch reads byte address 0 with its strobe high one cycle after reset is released.
- R2: The read strobe stays high from the cycle after FETCH until the cycle in which completion is sampled high. The next strobe rises exactly 3 cycles after that completion edge.
- R3: The memory address holds the fetch address and does not change while the read strobe is high.
- R4: When the instruction is not a jump, the next fetch address is the previous fetch address plus 4.
- R5: Opcode 1 (instruction bits [31:26]) writes the sum modulo 2^32 of the registers named by bits [25:21] (bus A) and [20:16] (bus B) into the register named by bits [15:11].
- R6: Opcode 4 writes the constant 4 plus the register named by bits [20:16] into the register named by bits [15:11].
- R7: Opcode 2 copies the register named by bits [25:21] unchanged into the register named by bits [15:11].
- R8: Opcode 3 loads the program counter with the register named by bits [25:21] unchanged, and the next fetch uses that address.
- R9: An instruction that reads and writes the same register uses the old value as its operand. The new value is visible to the following instruction.
- R10: Any opcode other than 1 to 4 changes no register and no program counter beyond the normal step of 4.
- R11: The write strobe is never asserted.
- R12: A completion pulse that arrives while no read is pending is ignored and does not change the step timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address from the memory address register |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe |
| mem_done | input | 1 | Memory completion |

## Verification
A behavioural model in the bench keeps the register contents and the program counter, and predicts each fetch address. The read strobe is due one cycle after reset is released and three cycles after each completion edge. The bench counts the low-strobe cycles on falling edges and compares that count with these figures. Register results cannot be seen directly, so they are brought out through later jump instructions whose target address appears on the memory address lines. Memory latency varies from zero to three wait cycles, and a stray completion pulse is injected in the LOADIR step, to confirm that the timing depends only on real completions.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 6'd1,
        OP_MOV  = 6'd2,
        OP_JR   = 6'd3,
        OP_ADD4 = 6'd4
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS_A,
        ALU_PASS_B,
        ALU_ADD
    } alu_mode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_WAIT,
        ST_LOADIR,
        ST_EXEC
    } step_e;

    typedef struct packed {
        logic      pc_to_b;
        logic      mdr_to_b;
        logic      const_a;
        alu_mode_e alu_mode;
        logic      mar_load;
        logic      ir_load;
        logic      pc_load;
        logic      pc_bump;
        logic      rf_write;
        logic      mdr_load;
        logic      mem_read;
    } ctrl_t;

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] cells [N];

    // One flop row per register; reads are combinational and see the
    // value stored before the edge that performs a write.
    for (genvar g = 0; g < N; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we && (wa == AW'(g))) begin
                cells[g] <= wd;
            end
        end
    end

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

    // R9: a written row holds the bus C value after the edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells[$past(wa)] == $past(wd));

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int W    = 32,
    parameter int KVAL = 4
) (
    input  alu_mode_e    mode,
    input  logic         const_a,
    input  logic [W-1:0] bus_a,
    input  logic [W-1:0] bus_b,
    output logic [W-1:0] bus_c
);

    logic [W-1:0] opnd_a;

    assign opnd_a = const_a ? W'(KVAL) : bus_a;

    always_comb begin
        unique case (mode)
            ALU_PASS_A: bus_c = opnd_a;
            ALU_PASS_B: bus_c = bus_b;
            ALU_ADD:    bus_c = opnd_a + bus_b;
            default:    bus_c = bus_b;
        endcase
    end

endmodule

// File: rtl/tribus_incr.sv
module tribus_incr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    assign nxt = cur + W'(STEP);

endmodule

// File: rtl/tribus_seq.sv
module tribus_seq
    import tribus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_done,
    input  logic [OPC_W-1:0] opcode,
    output step_e            step,
    output ctrl_t            ctrl
);

    step_e step_q, step_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= ST_FETCH;
        else        step_q <= step_d;
    end

    always_comb begin
        unique case (step_q)
            ST_FETCH:  step_d = ST_WAIT;
            ST_WAIT:   step_d = mem_done ? ST_LOADIR : ST_WAIT;
            ST_LOADIR: step_d = ST_EXEC;
            ST_EXEC:   step_d = ST_FETCH;
            default:   step_d = ST_FETCH;
        endcase
    end

    always_comb begin
        ctrl          = '0;
        ctrl.alu_mode = ALU_PASS_B;
        unique case (step_q)
            ST_FETCH: begin
                ctrl.pc_to_b  = 1'b1;
                ctrl.mar_load = 1'b1;
                ctrl.pc_bump  = 1'b1;
            end
            ST_WAIT: begin
                ctrl.mem_read = 1'b1;
                ctrl.mdr_load = mem_done;
            end
            ST_LOADIR: begin
                ctrl.mdr_to_b = 1'b1;
                ctrl.ir_load  = 1'b1;
            end
            ST_EXEC: begin
                case (opcode)
                    OP_ADD: begin
                        ctrl.alu_mode = ALU_ADD;
                        ctrl.rf_write = 1'b1;
                    end
                    OP_ADD4: begin
                        ctrl.alu_mode = ALU_ADD;
                        ctrl.const_a  = 1'b1;
                        ctrl.rf_write = 1'b1;
                    end
                    OP_MOV: begin
                        ctrl.alu_mode = ALU_PASS_A;
                        ctrl.rf_write = 1'b1;
                    end
                    OP_JR: begin
                        ctrl.alu_mode = ALU_PASS_A;
                        ctrl.pc_load  = 1'b1;
                    end
                    default: ctrl.alu_mode = ALU_PASS_B;
                endcase
            end
            default: ctrl.alu_mode = ALU_PASS_B;
        endcase
    end

    assign step = step_q;

    // R2: the strobe is held until completion
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mem_read && !mem_done) |=> ctrl.mem_read);

    // R2: the instruction register load is always followed by execution
    p_exec_after_ir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ir_load |=> (step_q == ST_EXEC));

    // R12: completion outside WAIT does not enter LOADIR
    p_stray_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_WAIT) |=> (step_q != ST_LOADIR));

endmodule

// File: rtl/tribus_core.sv
module tribus_core
    import tribus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    parameter int PC_STEP = 4,
    localparam int RIDX_W = $clog2(NREGS),
    localparam int OP_LSB = DATA_W - OPC_W,
    localparam int RS_LSB = OP_LSB - RIDX_W,
    localparam int RT_LSB = RS_LSB - RIDX_W,
    localparam int RD_LSB = RT_LSB - RIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_done
);

    ctrl_t              ctrl;
    step_e              step;
    logic [DATA_W-1:0]  pc_q, mar_q, mdr_q, ir_q;
    logic [DATA_W-1:0]  pc_next;
    logic [DATA_W-1:0]  bus_a, bus_b, bus_c;
    logic [DATA_W-1:0]  rf_a, rf_b;
    logic [RIDX_W-1:0]  f_rs, f_rt, f_rd;

    assign f_rs = ir_q[RS_LSB +: RIDX_W];
    assign f_rt = ir_q[RT_LSB +: RIDX_W];
    assign f_rd = ir_q[RD_LSB +: RIDX_W];

    tribus_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_done (mem_done),
        .opcode   (ir_q[OP_LSB +: OPC_W]),
        .step     (step),
        .ctrl     (ctrl)
    );

    tribus_regfile #(.W(DATA_W), .N(NREGS)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (f_rs),
        .ra_b  (f_rt),
        .we    (ctrl.rf_write),
        .wa    (f_rd),
        .wd    (bus_c),
        .rd_a  (rf_a),
        .rd_b  (rf_b)
    );

    assign bus_a = rf_a;
    assign bus_b = ctrl.pc_to_b  ? pc_q  :
                   ctrl.mdr_to_b ? mdr_q : rf_b;

    tribus_alu #(.W(DATA_W), .KVAL(4)) i_alu (
        .mode    (ctrl.alu_mode),
        .const_a (ctrl.const_a),
        .bus_a   (bus_a),
        .bus_b   (bus_b),
        .bus_c   (bus_c)
    );

    tribus_incr #(.W(DATA_W), .STEP(PC_STEP)) i_incr (
        .cur (pc_q),
        .nxt (pc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctrl.pc_load)       pc_q <= bus_c;
            else if (ctrl.pc_bump)  pc_q <= pc_next;
            if (ctrl.mar_load)      mar_q <= bus_c;
            if (ctrl.mdr_load)      mdr_q <= mem_rdata;
            if (ctrl.ir_load)       ir_q  <= bus_c;
        end
    end

    assign mem_addr = mar_q;
    assign mem_rd   = ctrl.mem_read;
    assign mem_wr   = 1'b0;

    // R3: the address does not move during a pending read
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_done) |=> $stable(mem_addr));

    // R4: the incrementer advances the program counter by the step
    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_bump |=> pc_q == $past(pc_q) + DATA_W'(PC_STEP));

    // R8: a jump loads bus C into the program counter
    p_jump_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_load |=> pc_q == $past(bus_a));

    // R2: the instruction register receives the captured memory word
    p_ir_from_mdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ir_load |=> ir_q == $past(mdr_q));

    // R1: no read strobe in the first step after reset
    p_fetch_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FETCH) |-> !mem_rd);

endmodule

// File: tb/test_tribus_core.sv
module test_tribus_core;

    logic        clk;
    logic        rst_n;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic        mem_done;

    int checks;
    int fails;

    tribus_core i_tribus_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_done  (mem_done)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int rs, input int rt,
                                        input int rd);
        return {6'(op), 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic logic [31:0] prog(input logic [31:0] a);
        case (a >> 2)
            0:  return enc(4, 0, 0, 1);    // r1 = 4 + r0          R6
            1:  return enc(1, 1, 1, 2);    // r2 = r1 + r1         R5
            2:  return enc(1, 2, 2, 2);    // r2 = r2 + r2         R9
            3:  return enc(2, 2, 0, 3);    // r3 = r2              R7
            4:  return enc(4, 0, 3, 3);    // r3 = 4 + r3          R6, R9
            5:  return enc(1, 3, 2, 4);    // r4 = r3 + r2         R5
            6:  return enc(4, 0, 4, 4);    // r4 = 4 + r4
            7:  return enc(3, 4, 0, 0);    // jump to r4           R8
            8:  return enc(4, 0, 4, 4);    // skipped
            9:  return enc(4, 0, 4, 4);    // skipped
            10: return enc(63, 4, 4, 4);   // unknown code         R10
            11: return enc(3, 4, 0, 0);    // jump to r4           R8, R10
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] regs [32];
        logic [31:0] exp_pc;
        logic [31:0] word;
        string       tag;
        int          n;
        int          lat;
        int          op, rs, rt, rd;
        bit          spur;

        checks   = 0;
        fails    = 0;
        mem_done = 1'b0;
        mem_rdata = '0;
        rst_n    = 1'b0;
        for (int i = 0; i < 32; i++) regs[i] = '0;
        exp_pc = '0;
        tag    = "R1";

        repeat (3) @(negedge clk);
        chk(mem_rd == 1'b0, "R1 reset strobe", 32'(mem_rd), 0);
        chk(mem_wr == 1'b0, "R11 reset write", 32'(mem_wr), 0);
        rst_n = 1'b1;

        for (int k = 0; k < 60; k++) begin
            // count low-strobe cycles up to the next fetch
            n    = 0;
            spur = (k % 3) == 0 && k != 0;
            while (!mem_rd && n < 12) begin
                chk(mem_wr == 1'b0, "R11 write strobe", 32'(mem_wr), 0);
                n++;
                mem_done = spur && (n == 1);
                @(negedge clk);
            end
            mem_done = 1'b0;
            if (k == 0) chk(n == 1, "R1 first strobe delay", 32'(n), 1);
            else if (spur) chk(n == 3, "R12 gap with stray completion", 32'(n), 3);
            else chk(n == 3, "R2 strobe gap", 32'(n), 3);
            chk(mem_addr == exp_pc, tag, mem_addr, exp_pc);

            lat = k % 4;
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(mem_rd == 1'b1, "R2 strobe held", 32'(mem_rd), 1);
                chk(mem_addr == exp_pc, "R3 address stable", mem_addr, exp_pc);
            end
            word      = prog(exp_pc);
            mem_rdata = word;
            mem_done  = 1'b1;
            @(negedge clk);
            mem_done  = 1'b0;

            // reference model of the instruction just fetched
            op = int'(word[31:26]);
            rs = int'(word[25:21]);
            rt = int'(word[20:16]);
            rd = int'(word[15:11]);
            exp_pc = exp_pc + 32'd4;
            case (op)
                1: begin regs[rd] = regs[rs] + regs[rt]; tag = "R5 R9 add then R4 fetch"; end
                2: begin regs[rd] = regs[rs];            tag = "R7 copy then R4 fetch"; end
                3: begin exp_pc = regs[rs];              tag = "R8 jump target"; end
                4: begin regs[rd] = 32'd4 + regs[rt];    tag = "R6 add four then R4 fetch"; end
                default: tag = "R10 unknown code then R4 fetch";
            endcase
        end

        // R5 R6 R7 R9: after the loop, register 4 must hold 40, seen via jump target
        chk(regs[4] == 32'd40, "R5 model sanity", regs[4], 32'd40);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule